// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Status Flags

This block is the integer add/subtract datapath of a 32-bit processor pipeline. Each accepted request names an operation and where the second operand comes from. The unit then returns the arithmetic result, a write strobe for the destination register and a fresh set of status bits. The operations are add, subtract, reverse subtract, compare, and saturating forms of add, subtract and reverse subtract. The B operand is either the first register value or an immediate, sign-extended from 5 or 16 bits.

A two-state control machine sequences the output. In ST_IDLE no result is presented. A request (`in_valid` high) causes the transition IDLE->DONE. ST_DONE presents the registered result for one cycle. It takes the transition DONE->DONE when another request arrives in that cycle, and DONE->IDLE when none does. The zero, sign, carry and overflow bits are rewritten by every request and hold between requests. The saturation bit is sticky: it can only be set by a saturating operation that overflows, and only reset clears it.

Top module: `satalu_core`

## Requirements
- R1: `src_sel` picks operand X: 0 = `reg1`, 1 = `imm[4:0]` sign-extended to 32 bits, 2 = `imm[15:0]` sign-extended to 32 bits, 3 = `reg1`.
- R2: `op` encodings: 0 add (X + reg2), 1 subtract (reg2 - X), 2 reverse subtract (X - reg2), 3 compare (reg2 - X), 4 saturating add, 5 saturating subtract, 6 saturating reverse subtract, 7 behaves as compare. `result` carries the 32-bit outcome.
- R3: `out_valid`, `result`, `wr_en` and the flags for a request appear at the first rising edge after the one that samples `in_valid` high. `out_valid` is low in every cycle that follows a cycle without a request.
- R4: `wr_en` is high with `out_valid` for every operation except compare (codes 3 and 7), and it is low whenever `out_valid` is low.
- R5: `flag_cy` is the unsigned carry out of an addition. For a subtraction it is the unsigned borrow, meaning the minuend is below the subtrahend.
- R6: `flag_ov` is set on two's-complement overflow. For an add, this is operands of equal sign with a result of the other sign. For a subtraction, it is operands of differing sign with a result whose sign differs from the minuend.
- R7: `flag_s` is the sign of the exact, infinitely wide result. It equals the wrapped result's top bit inverted when `flag_ov` is set.
- R8: `flag_z` is set exactly when the value in `result` is zero, evaluated after any clamping.
- R9: A saturating operation that overflows returns 0x7FFFFFFF when the exact result is positive and 0x80000000 when it is negative. Without overflow it returns the wrapped value.
- R10: `flag_sat` is set by a saturating operation that overflows. Later operations of any kind never clear it; only reset does.
- R11: In cycles without a request, `flag_z`, `flag_s`, `flag_cy`, `flag_ov` and `flag_sat` keep their values.
- R12: During and after reset, before any request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| src_sel | input | 2 | Operand X source |
| reg1 | input | 32 | First register value |
| reg2 | input | 32 | Second register value |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result present |
| result | output | 32 | Arithmetic result |
| wr_en | output | 1 | Destination write strobe |
| flag_z | output | 1 | Zero |
| flag_s | output | 1 | Sign |
| flag_cy | output | 1 | Carry / borrow |
| flag_ov | output | 1 | Signed overflow |
| flag_sat | output | 1 | Sticky saturation |

## Verification
Directed operand pairs sit on the boundaries where the flag rules separate. One group is all-ones plus one, which gives carry with zero. Another is the positive limit plus one and the negative limit minus one, which give overflow with the sign inverted. Equal operands in compare give zero with no write. Each subtract pattern also runs in reverse-subtract form, so that a swapped minuend shows up in both the result and the overflow bit. Both immediate widths are driven with negative values to separate sign extension from zero extension. The saturating forms run into positive and into negative overflow, followed by plain operations, which shows whether the clamp direction and the stickiness of the saturation bit are right. A long run of pseudo-random operands, with back-to-back and idle cycles mixed in, covers the ordinary paths and flag holding.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_RSUB  = 3'd2,
        OP_CMP   = 3'd3,
        OP_SADD  = 3'd4,
        OP_SSUB  = 3'd5,
        OP_SRSUB = 3'd6,
        OP_CMPX  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_SHORT = 2'd1,
        SRC_LONG  = 2'd2,
        SRC_ALT   = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    // x_first: operand X is the minuend (or first addend)
    typedef struct packed {
        logic subtract;
        logic x_first;
        logic saturate;
        logic write;
    } ctl_t;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } flags_t;

    function automatic ctl_t decode_op(op_e code);
        ctl_t c;
        unique case (code)
            OP_ADD:   c = '{subtract: 1'b0, x_first: 1'b1, saturate: 1'b0, write: 1'b1};
            OP_SUB:   c = '{subtract: 1'b1, x_first: 1'b0, saturate: 1'b0, write: 1'b1};
            OP_RSUB:  c = '{subtract: 1'b1, x_first: 1'b1, saturate: 1'b0, write: 1'b1};
            OP_CMP:   c = '{subtract: 1'b1, x_first: 1'b0, saturate: 1'b0, write: 1'b0};
            OP_SADD:  c = '{subtract: 1'b0, x_first: 1'b1, saturate: 1'b1, write: 1'b1};
            OP_SSUB:  c = '{subtract: 1'b1, x_first: 1'b0, saturate: 1'b1, write: 1'b1};
            OP_SRSUB: c = '{subtract: 1'b1, x_first: 1'b1, saturate: 1'b1, write: 1'b1};
            OP_CMPX:  c = '{subtract: 1'b1, x_first: 1'b0, saturate: 1'b0, write: 1'b0};
            default:  c = '{subtract: 1'b1, x_first: 1'b0, saturate: 1'b0, write: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/satalu_opsel.sv
module satalu_opsel
    import satalu_pkg::*;
#(
    parameter int W       = 32,
    parameter int SHORT_W = 5,
    parameter int LONG_W  = 16
) (
    input  logic [1:0]        src_sel,
    input  logic [W-1:0]      reg1,
    input  logic [LONG_W-1:0] imm,
    output logic [W-1:0]      opnd_x
);
    localparam int SHORT_PAD = W - SHORT_W;
    localparam int LONG_PAD  = W - LONG_W;

    logic [W-1:0] short_ext;
    logic [W-1:0] long_ext;

    generate
        if (SHORT_PAD > 0) begin : g_short_pad
            assign short_ext = {{SHORT_PAD{imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
        end else begin : g_short_full
            assign short_ext = imm[W-1:0];
        end
        if (LONG_PAD > 0) begin : g_long_pad
            assign long_ext = {{LONG_PAD{imm[LONG_W-1]}}, imm};
        end else begin : g_long_full
            assign long_ext = imm[W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (src_e'(src_sel))
            SRC_SHORT: opnd_x = short_ext;
            SRC_LONG:  opnd_x = long_ext;
            SRC_REG,
            SRC_ALT:   opnd_x = reg1;
            default:   opnd_x = reg1;
        endcase
    end

endmodule

// File: rtl/satalu_arith.sv
module satalu_arith #(
    parameter int W = 32
) (
    input  logic         subtract,
    input  logic [W-1:0] minu,
    input  logic [W-1:0] subt,
    output logic [W-1:0] wrapped,
    output logic         carry,
    output logic         overflow
);
    localparam int MSB = W - 1;

    logic [W-1:0] subt_eff;
    logic [W:0]   wide;

    always_comb begin
        subt_eff = subtract ? ~subt : subt;
        wide     = {1'b0, minu} + {1'b0, subt_eff} + {{W{1'b0}}, subtract};
        wrapped  = wide[W-1:0];
        // borrow is the inverted carry of the complemented addition
        carry    = subtract ? ~wide[W] : wide[W];
        overflow = (minu[MSB] == subt_eff[MSB]) && (wrapped[MSB] != minu[MSB]);
    end

endmodule

// File: rtl/satalu_clamp.sv
module satalu_clamp #(
    parameter int W = 32
) (
    input  logic         enable,
    input  logic         overflow,
    input  logic [W-1:0] wrapped,
    output logic [W-1:0] final_val,
    output logic         clamped
);
    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        clamped = enable && overflow;
        if (clamped) begin
            // a wrapped negative value means the exact result was positive
            final_val = wrapped[W-1] ? POS_LIMIT : NEG_LIMIT;
        end else begin
            final_val = wrapped;
        end
    end

    always_comb begin
        if (clamped) begin
            // R9
            clamp_dir_chk: assert (final_val[W-1] != wrapped[W-1]);
        end
    end

endmodule

// File: rtl/satalu_core.sv
module satalu_core
    import satalu_pkg::*;
#(
    parameter int W       = 32,
    parameter int SHORT_W = 5,
    parameter int LONG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [1:0]        src_sel,
    input  logic [W-1:0]      reg1,
    input  logic [W-1:0]      reg2,
    input  logic [LONG_W-1:0] imm,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_cy,
    output logic              flag_ov,
    output logic              flag_sat
);
    localparam int MSB = W - 1;

    ctl_t         ctl;
    logic [W-1:0] opnd_x;
    logic [W-1:0] minu;
    logic [W-1:0] subt;
    logic [W-1:0] wrapped;
    logic         carry;
    logic         overflow;
    logic [W-1:0] final_val;
    logic         clamped;
    flags_t       flags_n;

    state_e       state_q, state_n;
    logic [W-1:0] result_q;
    logic         write_q;
    flags_t       flags_q;
    logic         sat_q;

    assign ctl = decode_op(op_e'(op));

    satalu_opsel #(.W(W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_opsel (
        .src_sel (src_sel),
        .reg1    (reg1),
        .imm     (imm),
        .opnd_x  (opnd_x)
    );

    always_comb begin
        minu = ctl.x_first ? opnd_x : reg2;
        subt = ctl.x_first ? reg2   : opnd_x;
    end

    satalu_arith #(.W(W)) u_arith (
        .subtract (ctl.subtract),
        .minu     (minu),
        .subt     (subt),
        .wrapped  (wrapped),
        .carry    (carry),
        .overflow (overflow)
    );

    satalu_clamp #(.W(W)) u_clamp (
        .enable    (ctl.saturate),
        .overflow  (overflow),
        .wrapped   (wrapped),
        .final_val (final_val),
        .clamped   (clamped)
    );

    always_comb begin
        flags_n.z  = (final_val == '0);
        flags_n.s  = wrapped[MSB] ^ overflow;
        flags_n.cy = carry;
        flags_n.ov = overflow;
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_n = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_n = in_valid ? ST_DONE : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            write_q  <= 1'b0;
            flags_q  <= '0;
            sat_q    <= 1'b0;
        end else if (in_valid) begin
            result_q <= final_val;
            write_q  <= ctl.write;
            flags_q  <= flags_n;
            sat_q    <= sat_q | clamped;
        end
    end

    // outputs
    always_comb begin
        result   = result_q;
        flag_z   = flags_q.z;
        flag_s   = flags_q.s;
        flag_cy  = flags_q.cy;
        flag_ov  = flags_q.ov;
        flag_sat = sat_q;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
                wr_en     = 1'b0;
            end
            ST_DONE: begin
                out_valid = 1'b1;
                wr_en     = write_q;
            end
            default: begin
                out_valid = 1'b0;
                wr_en     = 1'b0;
            end
        endcase
    end

    // R3
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd3 || op == 3'd7)) |=> !wr_en);

    // R4
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);

    // R10
    sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sat |=> flag_sat);

    // R10
    sat_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[2] && !flag_sat) |=> !flag_sat);

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({flag_z, flag_s, flag_cy, flag_ov}));

    // R8
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_z) |-> (result == '0));

    // R9
    sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2] && !op[1] | (in_valid && op[2] && !op[0])) |=>
        (!flag_ov || result == 32'h7FFF_FFFF || result == 32'h8000_0000));

endmodule

// File: tb/tb_satalu_core.sv
module tb_satalu_core;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic        z;
        logic        s;
        logic        cy;
        logic        ov;
        logic        sat;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  src_sel = '0;
    logic [31:0] reg1 = '0;
    logic [31:0] reg2 = '0;
    logic [15:0] imm = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_z, flag_s, flag_cy, flag_ov, flag_sat;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    exp_t sb[$];
    exp_t last;
    logic model_sat = 1'b0;

    always #10 clk = ~clk;

    satalu_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_sel(src_sel), .reg1(reg1), .reg2(reg2), .imm(imm),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy),
        .flag_ov(flag_ov), .flag_sat(flag_sat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [2:0] code, input logic [1:0] sel,
                                   input logic [31:0] a1, input logic [31:0] a2,
                                   input logic [15:0] im);
        exp_t e;
        logic [31:0] x, m, n;
        logic is_sub, xf, sat_op;
        longint exact;
        // R1: operand source
        case (sel)
            2'd1:    x = {{27{im[4]}}, im[4:0]};
            2'd2:    x = {{16{im[15]}}, im};
            default: x = a1;
        endcase
        // R2: operation table
        is_sub = (code != 3'd0 && code != 3'd4);
        xf     = (code == 3'd0 || code == 3'd2 || code == 3'd4 || code == 3'd6);
        sat_op = (code == 3'd4 || code == 3'd5 || code == 3'd6);
        e.wr   = (code != 3'd3 && code != 3'd7);
        m = xf ? x : a2;
        n = xf ? a2 : x;
        if (is_sub) exact = longint'($signed(m)) - longint'($signed(n));
        else        exact = longint'($signed(m)) + longint'($signed(n));
        e.ov = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
        if (is_sub) e.cy = (m < n);
        else        e.cy = ((33'(m) + 33'(n)) >> 32) != 0;
        e.s = (exact < 0);
        if (sat_op && e.ov) e.res = (exact > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        else                e.res = exact[31:0];
        e.z = (e.res == 32'h0);
        model_sat = model_sat | (sat_op & e.ov);
        e.sat = model_sat;
        return e;
    endfunction

    task automatic issue(input logic [2:0] code, input logic [1:0] sel,
                         input logic [31:0] a1, input logic [31:0] a2,
                         input logic [15:0] im);
        @(negedge clk);
        op = code; src_sel = sel; reg1 = a1; reg2 = a2; imm = im;
        in_valid = 1'b1;
        sb.push_back(model(code, sel, a1, a2, im));
    endtask

    task automatic pause(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            reg1 = 32'hDEAD_BEEF;
            reg2 = 32'h0BAD_F00D;
        end
    endtask

    // monitor / scoreboard
    initial begin
        last = '{res: 32'h0, wr: 1'b0, z: 1'b0, s: 1'b0, cy: 1'b0, ov: 1'b0, sat: 1'b0};
        forever begin
            @(posedge clk);
            #5;
            if (mon_on) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        total++; bad++;
                        $display("FAIL R3 actual=out_valid expected=no result pending");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check("R1 R2 R9 result", result, e.res);
                        check("R4 wr_en", {31'b0, wr_en}, {31'b0, e.wr});
                        check("R8 flag_z", {31'b0, flag_z}, {31'b0, e.z});
                        check("R7 flag_s", {31'b0, flag_s}, {31'b0, e.s});
                        check("R5 flag_cy", {31'b0, flag_cy}, {31'b0, e.cy});
                        check("R6 flag_ov", {31'b0, flag_ov}, {31'b0, e.ov});
                        check("R10 flag_sat", {31'b0, flag_sat}, {31'b0, e.sat});
                        last = e;
                    end
                end else begin
                    check("R3 R12 out_valid/wr_en idle", {30'b0, out_valid, wr_en}, 32'h0);
                    check("R11 R12 flags held", {27'b0, flag_z, flag_s, flag_cy, flag_ov, flag_sat},
                          {27'b0, last.z, last.s, last.cy, last.ov, last.sat});
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !finished) begin
                total++; bad++;
                $display("FAIL R3 watchdog actual=%0d cycles expected<20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    // stimulus
    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs during reset
        check("R12 reset result", result, 32'h0);
        check("R12 reset controls", {25'b0, out_valid, wr_en, flag_z, flag_s, flag_cy, flag_ov, flag_sat}, 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        pause(2);

        // R2 plain add, R5 carry with zero (R8)
        issue(3'd0, 2'd0, 32'd5, 32'd7, 16'h0);
        issue(3'd0, 2'd0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        // R6 R7 positive and negative overflow on add
        issue(3'd0, 2'd0, 32'h7FFF_FFFF, 32'h1, 16'h0);
        issue(3'd0, 2'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
        pause(1);
        // subtract: borrow, overflow
        issue(3'd1, 2'd0, 32'd9, 32'd4, 16'h0);
        issue(3'd1, 2'd0, 32'h1, 32'h8000_0000, 16'h0);
        // reverse subtract: same operands, swapped roles
        issue(3'd2, 2'd0, 32'd9, 32'd4, 16'h0);
        issue(3'd2, 2'd0, 32'h1, 32'h8000_0000, 16'h0);
        // R4 compare equal: zero, no write
        issue(3'd3, 2'd0, 32'h1234_5678, 32'h1234_5678, 16'h0);
        issue(3'd7, 2'd0, 32'd3, 32'd2, 16'h0);
        // R1 immediates, negative values
        issue(3'd0, 2'd1, 32'hFFFF, 32'd10, 16'hFFF0);
        issue(3'd0, 2'd2, 32'hFFFF, 32'd10, 16'h8000);
        issue(3'd0, 2'd3, 32'd100, 32'd10, 16'h8000);
        issue(3'd5, 2'd2, 32'h0, 32'd100, 16'h0010);
        pause(3);
        // R9 R10 saturation positive, then sticky across ordinary ops
        issue(3'd4, 2'd0, 32'h7FFF_FFF0, 32'h100, 16'h0);
        issue(3'd0, 2'd0, 32'd1, 32'd1, 16'h0);
        pause(2);
        issue(3'd5, 2'd0, 32'h1, 32'h8000_0000, 16'h0);
        issue(3'd6, 2'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        issue(3'd6, 2'd0, 32'd20, 32'd5, 16'h0);
        issue(3'd4, 2'd1, 32'h0, 32'h8000_0000, 16'h001F);
        pause(2);

        // reset again to clear SAT and then random mix
        @(negedge clk);
        rst_n = 1'b0; mon_on = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 R12 sat cleared by reset", {31'b0, flag_sat}, 32'h0);
        rst_n = 1'b1;
        model_sat = 1'b0;
        sb.delete();
        last = '{res: 32'h0, wr: 1'b0, z: 1'b0, s: 1'b0, cy: 1'b0, ov: 1'b0, sat: 1'b0};
        mon_on = 1'b1;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 7 == 0) ra = {ra[31], {31{~ra[31]}}};
            issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), ra, rb, 16'($urandom()));
            if (i % 5 == 0) pause(1);
        end
        pause(3);
        check("R3 scoreboard drained", 32'(sb.size()), 32'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule